// File: doc/BRIEF.md
# Four-Channel Two-Stage PWM Generator

This block produces four pulse-width-modulated outputs from one system clock. The clock is divided in two stages. A first-stage prescaler is shared by each pair of channels. A per-channel selector then divides that prescaled tick further. Each channel has its own down-counter and comparator. The counter period and the duty are set by a reload register and a comparator register.

Software controls the block through a small 32-bit register bus. The bus has an address, a write strobe, write data and read data, and the read data is registered. The per-channel enable, invert and run-mode bits all sit in one shared control word. Reload and comparator values written while a channel runs are held back until that channel's next reload, so no period is ever cut short. An interrupt-enable word is kept at its offset only so that software can store a value there. The interrupt status word reads zero.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset `pwm_out` is 0, the clock-selector word (byte offset 0x4) reads 0x4444, and every other register reads 0. Read data appears one clock after the address is presented.
- R2: The prescale word at 0x0 holds two 8-bit fields. Bits 7:0 clock channels 0 and 1, and bits 15:8 clock channels 2 and 3. A field value P gives one prescaled tick every P+1 clocks.
- R3: A prescale field of 0 stops its pair of channels. Their counters and outputs then do not change.
- R4: The selector word at 0x4 gives channel n a 4-bit code at bits 4n+3:4n. Code 4 passes every prescaled tick. Codes 0, 1, 2 and 3 pass one tick in 2, 4, 8 and 16. Codes 5 to 15 act as code 4.
- R5: Channel n has its reload at 0xC+12n and its comparator at 0x10+12n. An enabled channel counts down from the reload value R to 0, one step per selected tick. Its output is high while the count is less than or equal to the comparator C. One period therefore lasts R+1 ticks, and min(C,R)+1 of those ticks are high.
- R6: The control word at 0x8 holds an invert bit for each channel, at bits 2, 10, 14 and 18 for channels 0 to 3. When that bit is set, the channel output is the complement.
- R7: Each channel has a run-mode bit in the control word, at bits 3, 11, 15 and 19. When the bit is 1, the counter reloads after reaching 0. When it is 0, the counter stops at 0 and the output stays at its active level.
- R8: The enable bits are at control bits 0, 8, 12 and 16. A channel whose enable bit is 0 holds its counter at the reload value and drives its output to the value of its invert bit. The word at 0x14+12n returns channel n's live count and ignores writes.
- R9: A reload or comparator value written while a channel runs is used only from that channel's next reload onward.
- R10: Reserved control bits read as 0 and cannot be written, so the control word reads back at most 0x000DDD0D. The interrupt-enable word at 0x3C stores 4 bits. The status word at 0x40 and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the address |
| pwm_out | output | 4 | PWM outputs, one per channel |

## Verification
Channel 0 is swept across every comparator value from zero to beyond the reload value. This tells apart the off-by-one at the bottom of the count from the saturation at the top. Every selector code is tried with a fixed small period, which separates each divide ratio, including the out-of-range codes that must behave like divide-by-1. Prescale fields are set differently for the two channel pairs, with one field zero. This shows which field feeds which pair and that a zero field freezes its pair. Slow-tick runs of the one-shot mode and of mid-period reload writes show when a new value takes hold, which the live count register makes visible.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int OFF_PRE    = 'h00;
  localparam int OFF_SEL    = 'h04;
  localparam int OFF_CTL    = 'h08;
  localparam int OFF_RELOAD = 'h0C;
  localparam int OFF_CMP    = 'h10;
  localparam int OFF_COUNT  = 'h14;
  localparam int CH_STRIDE  = 12;
  localparam int OFF_IEN    = 'h3C;
  localparam int OFF_ISTAT  = 'h40;
  localparam logic [3:0] SEL_PASS = 4'd4;

  function automatic int en_pos(input int n);
    return (n == 0) ? 0 : 4 + 4 * n;
  endfunction

  function automatic logic [31:0] ctl_mask(input int nch);
    logic [31:0] m;
    m = '0;
    for (int n = 0; n < nch; n++) begin
      m[en_pos(n)]     = 1'b1;
      m[en_pos(n) + 2] = 1'b1;
      m[en_pos(n) + 3] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CW   = 16,
  parameter int PW   = 8,
  parameter int AW   = 8,
  localparam int NPRE = (NCH + 1) / 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic                     we,
  input  logic [31:0]              wdata,
  input  logic [NCH-1:0][CW-1:0]   live_count,
  output logic [NPRE*PW-1:0]       pre_q,
  output logic [4*NCH-1:0]         sel_q,
  output logic [NCH-1:0]           ch_en,
  output logic [NCH-1:0]           ch_inv,
  output logic [NCH-1:0]           ch_mode,
  output logic [NCH-1:0][CW-1:0]   reload_q,
  output logic [NCH-1:0][CW-1:0]   cmp_q,
  output logic [31:0]              rdata
);
  localparam logic [31:0] CTL_MASK = ctl_mask(NCH);

  logic [31:0]    ctl_q;
  logic [NCH-1:0] ien_q;
  logic [31:0]    rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      sel_q    <= {NCH{SEL_PASS}};
      ctl_q    <= '0;
      ien_q    <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
      rdata    <= '0;
    end else begin
      if (we) begin
        if (addr == AW'(OFF_PRE)) pre_q <= wdata[NPRE*PW-1:0];
        if (addr == AW'(OFF_SEL)) sel_q <= wdata[4*NCH-1:0];
        if (addr == AW'(OFF_CTL)) ctl_q <= wdata & CTL_MASK;
        if (addr == AW'(OFF_IEN)) ien_q <= wdata[NCH-1:0];
        for (int n = 0; n < NCH; n++) begin
          if (addr == AW'(OFF_RELOAD + CH_STRIDE * n)) reload_q[n] <= wdata[CW-1:0];
          if (addr == AW'(OFF_CMP + CH_STRIDE * n))    cmp_q[n]    <= wdata[CW-1:0];
        end
      end
      rdata <= rd_d;
    end
  end

  always_comb begin
    rd_d = '0;
    if (addr == AW'(OFF_PRE)) rd_d = 32'(pre_q);
    if (addr == AW'(OFF_SEL)) rd_d = 32'(sel_q);
    if (addr == AW'(OFF_CTL)) rd_d = ctl_q;
    if (addr == AW'(OFF_IEN)) rd_d = 32'(ien_q);
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(OFF_RELOAD + CH_STRIDE * n)) rd_d = 32'(reload_q[n]);
      if (addr == AW'(OFF_CMP + CH_STRIDE * n))    rd_d = 32'(cmp_q[n]);
      if (addr == AW'(OFF_COUNT + CH_STRIDE * n))  rd_d = 32'(live_count[n]);
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_bits
    assign ch_en[n]   = ctl_q[en_pos(n)];
    assign ch_inv[n]  = ctl_q[en_pos(n) + 2];
    assign ch_mode[n] = ctl_q[en_pos(n) + 3];
  end

  // R10: the stored control word never carries reserved bits
  p_ctl_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    we && addr == AW'(OFF_CTL) |=> (ctl_q & ~CTL_MASK) == 32'd0);
endmodule

// File: rtl/pwm4_prescale.sv
module pwm4_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R3: a zero field yields no ticks
  p_stopped_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    div == '0 |=> !tick);
  // R2: ticks are never back to back unless dividing by 2 or more is off
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tick && $stable(div) && div > PW'(1) |=> !tick);
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_in,
  input  logic [3:0]    sel,
  input  logic          en,
  input  logic          inv,
  input  logic          mode,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] cmp,
  output logic [CW-1:0] count,
  output logic          pwm
);
  logic [3:0]    div_cnt;
  logic [3:0]    div_mask;
  logic          step;
  logic [CW-1:0] cmp_act;

  always_comb begin
    case (sel)
      4'd0:    div_mask = 4'h1;
      4'd1:    div_mask = 4'h3;
      4'd2:    div_mask = 4'h7;
      4'd3:    div_mask = 4'hF;
      default: div_mask = 4'h0;
    endcase
    step = tick_in && ((div_cnt & div_mask) == div_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      count   <= '0;
      cmp_act <= '0;
      pwm     <= 1'b0;
    end else begin
      if (tick_in) div_cnt <= div_cnt + 1'b1;
      if (!en) begin
        count   <= reload;
        cmp_act <= cmp;
      end else if (step) begin
        if (count == '0) begin
          if (mode) begin
            count   <= reload;
            cmp_act <= cmp;
          end
        end else begin
          count <= count - 1'b1;
        end
      end
      pwm <= (en && (count <= cmp_act)) ^ inv;
    end
  end

  // R8: a disabled channel tracks its reload value
  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> count == $past(reload));
  // R6: a disabled output shows the invert bit
  p_out_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> pwm == $past(inv));
  // R7: auto-reload at the bottom of the count
  p_autoreload_r7: assert property (@(posedge clk) disable iff (rst)
    en && mode && step && count == '0 |=> count == $past(reload));
  // R7: one-shot stays parked at zero
  p_oneshot_park_r7: assert property (@(posedge clk) disable iff (rst)
    en && !mode && count == '0 |=> count == '0);
  // R3: no selected tick, no counter movement
  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    en && !step |=> $stable(count));
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int NPRE = (NCH + 1) / 2;

  logic [NPRE*PW-1:0]     pre_q;
  logic [4*NCH-1:0]       sel_q;
  logic [NCH-1:0]         ch_en, ch_inv, ch_mode;
  logic [NCH-1:0][CW-1:0] reload_q, cmp_q, live_count;
  logic [NPRE-1:0]        pre_tick;

  pwm4_regs #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .live_count(live_count), .pre_q(pre_q), .sel_q(sel_q),
    .ch_en(ch_en), .ch_inv(ch_inv), .ch_mode(ch_mode),
    .reload_q(reload_q), .cmp_q(cmp_q), .rdata(bus_rdata)
  );

  for (genvar g = 0; g < NPRE; g++) begin : g_pre
    pwm4_prescale #(.PW(PW)) u_pre (
      .clk(clk), .rst(rst), .div(pre_q[g*PW +: PW]), .tick(pre_tick[g])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm4_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .tick_in(pre_tick[n/2]), .sel(sel_q[4*n +: 4]),
      .en(ch_en[n]), .inv(ch_inv[n]), .mode(ch_mode[n]),
      .reload(reload_q[n]), .cmp(cmp_q[n]),
      .count(live_count[n]), .pwm(pwm_out[n])
    );
  end

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> pwm_out == '0);
endmodule

// File: tb/pwm4_ctrl_test.sv
module pwm4_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm4_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  initial begin
    logic [31:0] v, v2;
    int hi, dv, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pwm_out == 4'b0, "R1 pwm_out after reset", pwm_out, 0);
    rd(8'h04, v); chk(v == 32'h4444, "R1 selector default", v, 32'h4444);
    rd(8'h00, v); chk(v == 0, "R1 prescale reset", v, 0);
    rd(8'h08, v); chk(v == 0, "R1 control reset", v, 0);

    // R10 reserved bits and unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk(v == 32'h000D_DD0D, "R10 control mask", v, 32'h000D_DD0D);
    wr(8'h08, 32'h0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk(v == 32'hF, "R10 interrupt enable store", v, 32'hF);
    rd(8'h40, v); chk(v == 0, "R10 status reads zero", v, 0);
    rd(8'h44, v); chk(v == 0, "R10 unmapped offset", v, 0);
    rd(8'h02, v); chk(v == 0, "R10 misaligned offset", v, 0);

    // R8 disabled channel: output equals invert bit, count = reload, count read-only
    wr(8'h18, 32'd9);
    wr(8'h08, 32'h400);
    repeat (3) @(negedge clk);
    chk(pwm_out == 4'b0010, "R8 disabled inverted output", pwm_out, 4'b0010);
    rd(8'h20, v); chk(v == 9, "R8 count held at reload", v, 9);
    wr(8'h20, 32'd3);
    rd(8'h20, v); chk(v == 9, "R8 count register ignores writes", v, 9);
    wr(8'h08, 32'h0);

    // R5/R2 duty sweep on channel 0: P=1, reload 7, period 16 clocks
    wr(8'h00, 32'h0001);
    wr(8'h0C, 32'd7);
    wr(8'h08, 32'h9);
    for (int c = 0; c <= 9; c++) begin
      wr(8'h10, 32'(c));
      repeat (40) @(negedge clk);
      count_high(0, 32, hi);
      exp = 2 * ((c < 7 ? c : 7) + 1) * 2;
      chk(hi == exp, $sformatf("R5 duty comparator %0d", c), hi, exp);
    end

    // R6 invert on channel 0 with comparator 2
    wr(8'h10, 32'd2);
    wr(8'h08, 32'hD);
    repeat (40) @(negedge clk);
    count_high(0, 32, hi);
    chk(hi == 20, "R6 inverted duty", hi, 20);

    // R4 selector codes on channel 0: reload 3, comparator 1
    wr(8'h08, 32'h9);
    wr(8'h0C, 32'd3);
    wr(8'h10, 32'd1);
    for (int code = 0; code <= 5; code++) begin
      wr(8'h04, 32'h4440 | 32'(code));
      dv = (code < 4) ? (2 << code) : 1;
      repeat (2 * 8 * dv + 8) @(negedge clk);
      count_high(0, 16 * dv, hi);
      exp = 8 * dv;
      chk(hi == exp, $sformatf("R4 selector code %0d", code), hi, exp);
    end
    wr(8'h04, 32'h4444);

    // R2 pair mapping and R3 stopped pair: ch0/1 field 0, ch2/3 field 2
    wr(8'h24, 32'd4);
    wr(8'h28, 32'd1);
    wr(8'h08, 32'h9009);
    wr(8'h00, 32'h0200);
    repeat (40) @(negedge clk);
    count_high(2, 30, hi);
    chk(hi == 12, "R2 upper field drives channel 2", hi, 12);
    rd(8'h14, v);
    repeat (50) @(negedge clk);
    rd(8'h14, v2);
    chk(v == v2, "R3 stopped count frozen", v2, v);
    count_high(0, 60, hi);
    chk(hi == 0 || hi == 60, "R3 stopped output constant", hi, 60);

    // R9 mid-period reload change on channel 3 (slow tick: 256 clocks)
    wr(8'h08, 32'h0);
    wr(8'h00, 32'hFF01);
    wr(8'h30, 32'd15);
    wr(8'h34, 32'd0);
    wr(8'h08, 32'h9_0000);
    repeat (1024) @(negedge clk);
    rd(8'h38, v);
    chk(v > 3 && v <= 15, "R9 channel 3 counting from 15", v, 11);
    wr(8'h30, 32'd3);
    rd(8'h38, v);
    chk(v > 3, "R9 new reload not taken mid-period", v, 10);
    repeat (4096) @(negedge clk);
    rd(8'h38, v);
    chk(v <= 3, "R9 new reload taken after wrap", v, 3);

    // R7 one-shot on channel 1
    wr(8'h08, 32'h0);
    wr(8'h18, 32'd5);
    wr(8'h1C, 32'd2);
    wr(8'h08, 32'h100);
    repeat (60) @(negedge clk);
    rd(8'h20, v); chk(v == 0, "R7 one-shot parks at zero", v, 0);
    count_high(1, 20, hi);
    chk(hi == 20, "R7 one-shot output stays active", hi, 20);
    wr(8'h08, 32'h400);
    repeat (3) @(negedge clk);
    chk(pwm_out[1] == 1'b1, "R8 disable drives invert level", pwm_out[1], 1);
    rd(8'h20, v); chk(v == 5, "R8 disable restores reload", v, 5);
    wr(8'h08, 32'h0);
    repeat (3) @(negedge clk);
    chk(pwm_out == 4'b0, "R8 all disabled low", pwm_out, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule